// File: doc/BRIEF.md
# Write-Update Home Directory Controller

This block is the home node of a write-update coherence scheme with write-through, no-allocate caches. It holds the backing words for a set of blocks and, for every block, a bit-vector of the nodes that have asked for a copy. Requests arrive from the network, wait in a request queue, and are served one at a time in arrival order. Memory is the only owner of data and is always current. The directory therefore has no exclusive or dirty state.

A share request records its sender in the block's vector and answers with the whole block. A write request stores one word in memory. The controller then walks the block's vector from node 0 upward and sends one message per cycle. Each sharer other than the writer gets an update carrying the new word. The writer gets a write reply if it is itself a sharer. Caches drop lines without telling the home, so sharer bits are never cleared. Updates may therefore reach nodes that no longer hold the line, and the controller treats this as normal.

Top module: `wu_home_dir`

## Requirements
- R1: After reset, msg_valid is 0, req_ready is 1, every memory word reads as zero and every sharer vector is empty.
- R2: Requests are accepted when req_valid and req_ready are both 1 and are served strictly in acceptance order. req_ready is 0 exactly while DEPTH requests are waiting.
- R3: A share request (req_kind 0) from a node outside the block's set adds that node. In the cycle after the request leaves the queue, the controller emits msg_type 0 (share reply) to that node, with the full block in msg_data. Word w sits at bits [w*DW +: DW]. The block index is the upper bits of the address and the word offset is the lower log2(WORDS) bits.
- R4: A share request from a node already in the set leaves the set unchanged and still produces a share reply.
- R5: A write request (req_kind 1) stores req_data at the addressed word before any later request is served, so a later share reply shows it.
- R6: After a write, every sharer other than the writer receives msg_type 1 (update) carrying the word in the low DW bits of msg_data, with the upper bits zero. These messages go out one per cycle in ascending node order, starting in the cycle after the write leaves the queue.
- R7: If the writer is a sharer, it receives msg_type 2 (write reply) with the new word, in its ascending-order slot.
- R8: A write never adds the writer to the sharer set.
- R9: No further request leaves the queue until the last message of the current write has been emitted. A write to a block with no sharers emits nothing and takes a single cycle.
- R10: Sharer bits are never cleared, so every node that ever shared a block receives its later updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request queue has room |
| req_kind | input | 1 | 0 share request, 1 write request |
| req_node | input | NW | Requesting node |
| req_addr | input | AW | {block, word offset} |
| req_data | input | DW | Write word |
| msg_valid | output | 1 | Outgoing message present this cycle |
| msg_type | output | 2 | 0 share reply, 1 update, 2 write reply |
| msg_src | output | NW | Home node id (HOME_ID) |
| msg_dst | output | NW | Destination node |
| msg_addr | output | AW | Address the message concerns |
| msg_data | output | WORDS*DW | Block (share reply) or word in low bits |

## Verification
The hardest condition to reach from the ports is a full request queue while a long fan-out is running. The queue only fills when writes to heavily shared blocks stall the drain while new requests keep arriving. The stimulus first registers every node on one block. It then sends a burst of writes and share requests to that block with no gaps, so req_ready drops and later requests must wait behind several multi-message writes. A behavioural model predicts every message and every req_ready value cycle by cycle, and a long random run over a few blocks then mixes stale sharers, writer-is-sharer cases and empty vectors.

// File: rtl/wu_pkg.sv
`timescale 1ns/1ps
package wu_pkg;
  localparam logic [1:0] MSG_SHREP  = 2'd0;
  localparam logic [1:0] MSG_UPDATE = 2'd1;
  localparam logic [1:0] MSG_WRREP  = 2'd2;
  localparam logic REQ_SHARE = 1'b0;
  localparam logic REQ_WRITE = 1'b1;
  typedef enum logic {ST_ACCEPT, ST_FANOUT} ctl_state_e;
endpackage

// File: rtl/wu_req_fifo.sv
`timescale 1ns/1ps
module wu_req_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slots [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign dout  = slots[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) slots[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(DEPTH)); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty); // R2
endmodule

// File: rtl/wu_dir_store.sv
`timescale 1ns/1ps
module wu_dir_store #(
  parameter int NODES  = 4,
  parameter int WORDS  = 4,
  parameter int BLOCKS = 8,
  parameter int DW     = 16,
  localparam int NW = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int OW = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int BW = (BLOCKS > 1) ? $clog2(BLOCKS) : 1,
  localparam int LW = WORDS * DW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BW-1:0]    blk,
  input  logic [OW-1:0]    off,
  input  logic [NW-1:0]    node,
  input  logic             sh_en,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  output logic [LW-1:0]    line,
  output logic [NODES-1:0] sharers
);
  logic [DW-1:0]    mem [BLOCKS][WORDS];
  logic [NODES-1:0] dir [BLOCKS];

  for (genvar w = 0; w < WORDS; w++) begin : g_line
    assign line[w*DW +: DW] = mem[blk][w];
  end
  assign sharers = dir[blk];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < BLOCKS; b++) begin
        dir[b] <= '0;
        for (int w = 0; w < WORDS; w++) mem[b][w] <= '0;
      end
    end else begin
      if (sh_en) dir[blk][node] <= 1'b1;
      if (wr_en) mem[blk][off] <= wr_data;
    end
  end

  for (genvar b = 0; b < BLOCKS; b++) begin : g_sticky
    AST_SHARER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (dir[b] & $past(dir[b])) == $past(dir[b])); // R10
  end
  AST_WRITE_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> dir[$past(blk)] == $past(dir[blk])); // R8
  AST_SHARE_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
    sh_en |=> dir[$past(blk)][$past(node)]); // R3
endmodule

// File: rtl/wu_home_dir.sv
`timescale 1ns/1ps
module wu_home_dir #(
  parameter int NODES   = 4,
  parameter int WORDS   = 4,
  parameter int BLOCKS  = 8,
  parameter int DW      = 16,
  parameter int DEPTH   = 4,
  parameter int HOME_ID = 0,
  localparam int NW = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int OW = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int BW = (BLOCKS > 1) ? $clog2(BLOCKS) : 1,
  localparam int AW = BW + OW,
  localparam int LW = WORDS * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_kind,
  input  logic [NW-1:0] req_node,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          msg_valid,
  output logic [1:0]    msg_type,
  output logic [NW-1:0] msg_src,
  output logic [NW-1:0] msg_dst,
  output logic [AW-1:0] msg_addr,
  output logic [LW-1:0] msg_data
);
  import wu_pkg::*;

  localparam int RW = 1 + NW + AW + DW;

  // lowest set bit of a sharer vector: the next node to notify
  function automatic logic [NW-1:0] first_set(input logic [NODES-1:0] v);
    logic [NW-1:0] r;
    r = '0;
    for (int i = NODES - 1; i >= 0; i--) if (v[i]) r = NW'(i);
    return r;
  endfunction

  logic          q_full, q_empty, q_push;
  logic [RW-1:0] q_head;
  logic          h_kind;
  logic [NW-1:0] h_node;
  logic [AW-1:0] h_addr;
  logic [DW-1:0] h_data;

  ctl_state_e       state;
  logic [NODES-1:0] pend, pend_next;
  logic [NW-1:0]    pick, f_node;
  logic [AW-1:0]    f_addr;
  logic [DW-1:0]    f_word;
  logic [LW-1:0]    blk_line;
  logic [NODES-1:0] blk_sharers;

  // named internal events
  logic take, take_share, take_write, fan_step, fan_last;

  assign q_push    = req_valid && !q_full;
  assign req_ready = !q_full;
  assign {h_kind, h_node, h_addr, h_data} = q_head;

  assign take       = (state == ST_ACCEPT) && !q_empty;
  assign take_share = take && (h_kind == REQ_SHARE);
  assign take_write = take && (h_kind == REQ_WRITE);
  assign pick       = first_set(pend);
  assign pend_next  = pend & ~(NODES'(1) << pick);
  assign fan_step   = (state == ST_FANOUT);
  assign fan_last   = fan_step && (pend_next == '0);
  assign msg_src    = NW'(HOME_ID);

  wu_req_fifo #(.W(RW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(q_push),
    .din({req_kind, req_node, req_addr, req_data}),
    .pop(take), .dout(q_head), .empty(q_empty), .full(q_full)
  );

  wu_dir_store #(.NODES(NODES), .WORDS(WORDS), .BLOCKS(BLOCKS), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .blk(h_addr[AW-1:OW]), .off(h_addr[OW-1:0]), .node(h_node),
    .sh_en(take_share), .wr_en(take_write), .wr_data(h_data),
    .line(blk_line), .sharers(blk_sharers)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_ACCEPT;
      pend      <= '0;
      f_node    <= '0;
      f_addr    <= '0;
      f_word    <= '0;
      msg_valid <= 1'b0;
      msg_type  <= MSG_SHREP;
      msg_dst   <= '0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else begin
      msg_valid <= 1'b0;
      if (take_share) begin
        msg_valid <= 1'b1;
        msg_type  <= MSG_SHREP;
        msg_dst   <= h_node;
        msg_addr  <= h_addr;
        msg_data  <= blk_line;
      end
      if (take_write) begin
        f_node <= h_node;
        f_addr <= h_addr;
        f_word <= h_data;
        pend   <= blk_sharers;
        if (blk_sharers != '0) state <= ST_FANOUT;
      end
      if (fan_step) begin
        msg_valid <= 1'b1;
        msg_type  <= (pick == f_node) ? MSG_WRREP : MSG_UPDATE;
        msg_dst   <= pick;
        msg_addr  <= f_addr;
        msg_data  <= LW'(f_word);
        pend      <= pend_next;
        if (fan_last) state <= ST_ACCEPT;
      end
    end
  end

  AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_type != MSG_SHREP && $past(msg_valid && msg_type != MSG_SHREP))
      |-> msg_dst > $past(msg_dst)); // R6
  AST_WRREP_TO_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_type == MSG_WRREP) |-> msg_dst == f_node); // R7
  AST_FAN_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
    fan_step |=> msg_valid && msg_type != MSG_SHREP); // R9
  AST_TYPE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> msg_type != 2'd3); // R6
endmodule

// File: tb/tb_wu_home_dir.sv
`timescale 1ns/1ps
module tb_wu_home_dir;
  localparam int NODES = 4, WORDS = 4, BLOCKS = 8, DW = 16, DEPTH = 4;
  localparam int NW = 2, OW = 2, BW = 3, AW = BW + OW, LW = WORDS * DW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_kind = 1'b0;
  logic [NW-1:0] req_node = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic req_ready, msg_valid;
  logic [1:0] msg_type;
  logic [NW-1:0] msg_src, msg_dst;
  logic [AW-1:0] msg_addr;
  logic [LW-1:0] msg_data;

  always #4 clk = ~clk;

  wu_home_dir dut (.*);

  typedef struct { bit kind; int node; int addr; logic [DW-1:0] data; } rq_t;
  typedef struct { int typ; int dst; int addr; logic [LW-1:0] data; } ms_t;
  rq_t fq[$];
  ms_t mq[$];
  logic [DW-1:0] m [BLOCKS][WORDS];
  bit dir [BLOCKS][NODES];

  bit e_valid, e_ready;
  ms_t e;
  int total = 0, bad = 0;
  string phase = "R1";
  bit done = 0;

  // reference model, advanced on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      fq.delete(); mq.delete();
      for (int b = 0; b < BLOCKS; b++) for (int n = 0; n < NODES; n++) dir[b][n] = 0;
      for (int b = 0; b < BLOCKS; b++) for (int w = 0; w < WORDS; w++) m[b][w] = '0;
      e_valid = 0; e_ready = 1;
    end else begin
      automatic bit pushing = req_valid && (fq.size() < DEPTH);
      automatic rq_t nr = '{req_kind, int'(req_node), int'(req_addr), req_data};
      e_valid = 0;
      if (mq.size() > 0) begin
        e = mq.pop_front(); e_valid = 1;
      end else if (fq.size() > 0) begin
        automatic rq_t r = fq.pop_front();
        automatic int b = r.addr / WORDS;
        if (!r.kind) begin
          e.typ = 0; e.dst = r.node; e.addr = r.addr; e.data = '0;
          for (int w = 0; w < WORDS; w++) e.data[w*DW +: DW] = m[b][w];
          dir[b][r.node] = 1; e_valid = 1;
        end else begin
          m[b][r.addr % WORDS] = r.data;
          for (int n = 0; n < NODES; n++)
            if (dir[b][n]) mq.push_back('{(n == r.node) ? 2 : 1, n, r.addr, LW'(r.data)});
        end
      end
      if (pushing) fq.push_back(nr);
      e_ready = (fq.size() < DEPTH);
    end
  end

  task automatic chk(input bit ok, input string what, input string got, input string exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s [%s] %s got=%s exp=%s", what, phase, got, got == "" ? "" : "", exp);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) if (rst_n && !done) begin
    chk(req_ready == e_ready, "R2 ready", $sformatf("%0b", req_ready), $sformatf("%0b", e_ready));
    chk(msg_valid == e_valid, "R9 msg_valid", $sformatf("%0b", msg_valid), $sformatf("%0b", e_valid));
    if (msg_valid && e_valid) begin
      automatic string tg = (e.typ == 0) ? "R3 share reply" : (e.typ == 1) ? "R6 update" : "R7 write reply";
      chk(msg_type == 2'(e.typ) && msg_dst == NW'(e.dst) && msg_addr == AW'(e.addr)
          && msg_data == e.data && msg_src == '0, tg,
          $sformatf("t%0d d%0d a%0d %h", msg_type, msg_dst, msg_addr, msg_data),
          $sformatf("t%0d d%0d a%0d %h", e.typ, e.dst, e.addr, e.data));
    end
  end

  task automatic send(input bit k, input int n, input int blk, input int w, input int d);
    req_valid = 1; req_kind = k; req_node = NW'(n);
    req_addr = AW'(blk * WORDS + w); req_data = DW'(d);
    while (!e_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int c);
    req_valid = 0;
    repeat (c) @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    total++; bad++;
    $display("FAIL watchdog expired [%s] got=running exp=finished", phase);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    phase = "R1";
    chk(msg_valid == 0, "R1 reset msg_valid", $sformatf("%0b", msg_valid), "0");
    chk(req_ready == 1, "R1 reset ready", $sformatf("%0b", req_ready), "1");
    rst_n = 1;
    @(negedge clk);
    send(0, 1, 3, 0, 0); idle(4);                 // zero block after reset
    phase = "R3";
    send(0, 0, 1, 0, 0); send(0, 2, 1, 1, 0); send(0, 3, 1, 2, 0); idle(4);
    phase = "R4";
    send(0, 2, 1, 3, 0); idle(3);
    phase = "R7";
    send(1, 2, 1, 2, 16'hBEEF); idle(8);          // updates 0,3 and write reply 2
    phase = "R5";
    send(0, 1, 1, 0, 0); idle(4);
    phase = "R8";
    send(1, 3, 5, 1, 16'h1111); idle(2);          // no sharers: nothing emitted
    send(0, 2, 5, 0, 0); idle(3);
    send(1, 3, 5, 2, 16'h2222); idle(4);          // only node 2 updated
    send(1, 0, 5, 3, 16'h3333); idle(4);
    phase = "R9";
    for (int n = 0; n < NODES; n++) send(0, n, 6, 0, 0);
    for (int i = 0; i < 3 * DEPTH; i++) send(i % 3 == 2 ? 0 : 1, i % NODES, 6, i % WORDS, 16'h4000 + i);
    idle(40);
    phase = "R10";
    send(1, 1, 1, 3, 16'h5A5A); idle(8);          // stale sharers still updated
    phase = "R2";
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
      send($urandom_range(0, 9) < 4, $urandom_range(0, NODES - 1), $urandom_range(0, 3),
           $urandom_range(0, WORDS - 1), $urandom_range(0, 65535));
    end
    idle(60);
    finish_run();
  end
endmodule